// File: doc/BRIEF.md
# Supply Monitor Window and Glitch Filter

This block is the digital back end of a bank of supply-voltage monitors. Each channel delivers two raw comparator bits from the analog side: one that is high while the supply sits above its upper trip point, and one that is high while it sits above its lower trip point. Both bits are brought into the block clock domain through a two-register synchroniser. A per-channel mode bit then either passes the two comparisons through unchanged or folds them into an in-window flag. A per-channel stability filter turns each result into a clean status bit.

The filter is a consecutive-sample counter. A status bit takes a new value only after its input has differed from the current status for a full run of samples: a long run when the channel's filter-enable bit is set, and a short run when it is clear. Any sample that agrees with the current status restarts the run. With the default counts and an 8 MHz clock, the two runs give settling delays of 64 µs and 16 µs.

Top module: `supply_window_filter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every status output is 0.
- R2: A raw comparator change passes through two synchronising registers before it reaches the filter. A change presented just before a rising edge is therefore not counted until the second rising edge after it.
- R3: With window mode off, status A reports the filtered upper-trip comparison and status B reports the filtered lower-trip comparison of the same channel.
- R4: With the filter enabled, a held raw change appears on the status output at the rising edge numbered FILT_LONG+2, counting the first edge that samples it as edge 1. At edge FILT_LONG+1 the output still shows the old value.
- R5: With the filter disabled, the same rule applies with FILT_SHORT in place of FILT_LONG, so the change appears at edge FILT_SHORT+2.
- R6: A new value that is sampled for fewer consecutive edges than the active run length never reaches the status output. A value sampled for exactly the run length does reach it.
- R7: With window mode on, status A is the filtered value of (lower-trip bit AND NOT upper-trip bit), so it is 1 only while the supply is between the two trip points.
- R8: With window mode on, status B remains the filtered lower-trip comparison.
- R9: Channels are independent. A change or a configuration on one channel does not alter the status or the timing of another channel.
- R10: A falling transition (1 to 0) takes the same number of edges as a rising transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (8 MHz in the intended system) |
| rst | input | 1 | Synchronous active-high reset |
| cmp_up_i | input | NCH | Raw upper-trip comparator bit per channel; 1 = above the upper trip point |
| cmp_lo_i | input | NCH | Raw lower-trip comparator bit per channel; 1 = above the lower trip point |
| win_en_i | input | NCH | Per-channel window mode select |
| filt_en_i | input | NCH | Per-channel filter select; 1 = long run, 0 = short run |
| stat_a_o | output | NCH | Filtered status A per channel |
| stat_b_o | output | NCH | Filtered status B per channel |

## Verification
Two functions can fall in the same cycle: a bounce that would restart the run, and the expiry of that run. The bench provokes this by releasing a raw change one sampling edge before the run would complete. In that case the filter sees the reverted value on exactly the edge where its count would fire, and the status must stay unchanged. The bench then holds the change for exactly the run length, which must flip the status on edge run+2 even though the raw input has already reverted. Simultaneous changes on two channels with different filter settings are judged edge by edge, so that each output moves only at its own count.

// File: rtl/mon_pkg.sv
package mon_pkg;

    localparam int unsigned DEF_NCH        = 10;
    localparam int unsigned DEF_FILT_LONG  = 512;
    localparam int unsigned DEF_FILT_SHORT = 128;

    typedef struct packed {
        logic a;
        logic b;
    } stat_pair_t;

    function automatic stat_pair_t window_map(input logic up, input logic lo, input logic win);
        stat_pair_t r;
        if (win) begin
            r.a = lo & ~up;
            r.b = lo;
        end else begin
            r.a = up;
            r.b = lo;
        end
        return r;
    endfunction

endpackage

// File: rtl/mon_sync.sv
module mon_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/mon_debounce.sv
module mon_debounce #(
    parameter int unsigned FILT_LONG  = 512,
    parameter int unsigned FILT_SHORT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    input  logic long_i,
    output logic q_o
);
    localparam int unsigned CW = (FILT_LONG > 1) ? $clog2(FILT_LONG) : 1;
    localparam logic [CW-1:0] LIM_LONG  = CW'(FILT_LONG - 1);
    localparam logic [CW-1:0] LIM_SHORT = CW'(FILT_SHORT - 1);

    logic [CW-1:0] run_cnt;
    logic [CW-1:0] run_lim;
    logic          held;

    assign run_lim = long_i ? LIM_LONG : LIM_SHORT;

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= 1'b0;
            run_cnt <= '0;
        end else if (d_i == held) begin
            run_cnt <= '0;
        end else if (run_cnt >= run_lim) begin
            held    <= d_i;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign q_o = held;

    // R1: reset clears status and count
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (held == 1'b0 && run_cnt == '0));

    // R6: an input equal to the status never moves it
    p_match_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (d_i == held) |=> (held == $past(held)));

    // R4: the status flips only once the full run has been counted
    p_flip_after_run_r4: assert property (@(posedge clk) disable iff (rst)
        (held != $past(held)) |-> ($past(run_cnt) >= $past(run_lim)));

    // R10: a flip always moves toward the sampled input
    p_flip_direction_r10: assert property (@(posedge clk) disable iff (rst)
        (held != $past(held)) |-> (held == $past(d_i)));

    // R5: the counter never passes the long limit
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= LIM_LONG);
endmodule

// File: rtl/supply_window_filter.sv
module supply_window_filter
    import mon_pkg::*;
#(
    parameter int unsigned NCH        = DEF_NCH,
    parameter int unsigned FILT_LONG  = DEF_FILT_LONG,
    parameter int unsigned FILT_SHORT = DEF_FILT_SHORT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cmp_up_i,
    input  logic [NCH-1:0] cmp_lo_i,
    input  logic [NCH-1:0] win_en_i,
    input  logic [NCH-1:0] filt_en_i,
    output logic [NCH-1:0] stat_a_o,
    output logic [NCH-1:0] stat_b_o
);
    localparam int unsigned SW = 2 * NCH;

    logic [SW-1:0] raw_bus;
    logic [SW-1:0] sync_bus;

    assign raw_bus = {cmp_up_i, cmp_lo_i};

    mon_sync #(.W(SW)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (raw_bus),
        .q_o (sync_bus)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        stat_pair_t mapped;

        assign mapped = window_map(sync_bus[NCH + ch], sync_bus[ch], win_en_i[ch]);

        mon_debounce #(.FILT_LONG(FILT_LONG), .FILT_SHORT(FILT_SHORT)) deb_a_i (
            .clk    (clk),
            .rst    (rst),
            .d_i    (mapped.a),
            .long_i (filt_en_i[ch]),
            .q_o    (stat_a_o[ch])
        );

        mon_debounce #(.FILT_LONG(FILT_LONG), .FILT_SHORT(FILT_SHORT)) deb_b_i (
            .clk    (clk),
            .rst    (rst),
            .d_i    (mapped.b),
            .long_i (filt_en_i[ch]),
            .q_o    (stat_b_o[ch])
        );

        // R7: in window mode the in-window flag excludes the over-limit state
        p_window_excl_r7: assert property (@(posedge clk) disable iff (rst)
            (win_en_i[ch] && sync_bus[NCH + ch]) |-> !mapped.a);
    end
endmodule

// File: tb/supply_window_filter_tb_top.sv
module supply_window_filter_tb_top;
    localparam int NCH = 10;
    localparam int FL  = 512;
    localparam int FS  = 128;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] cmp_up = '0;
    logic [NCH-1:0] cmp_lo = '0;
    logic [NCH-1:0] win_en = '0;
    logic [NCH-1:0] filt_en = '1;
    logic [NCH-1:0] stat_a;
    logic [NCH-1:0] stat_b;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    supply_window_filter #(.NCH(NCH), .FILT_LONG(FL), .FILT_SHORT(FS)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmp_up_i  (cmp_up),
        .cmp_lo_i  (cmp_lo),
        .win_en_i  (win_en),
        .filt_en_i (filt_en),
        .stat_a_o  (stat_a),
        .stat_b_o  (stat_b)
    );

    task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        cmp_up = '1;
        cmp_lo = '1;
        edges(3);
        chk("R1 A in reset", stat_a, '0);
        chk("R1 B in reset", stat_b, '0);
        cmp_up = '0;
        cmp_lo = '0;
        edges(2);
        rst = 1'b0;
        edges(1);
        chk("R1 A after release", stat_a, '0);
        chk("R1 B after release", stat_b, '0);
        edges(4);
    endtask

    task automatic t_filtered_rise;
        filt_en[0] = 1'b1;
        cmp_up[0]  = 1'b1;
        edges(FL + 1);
        chk("R2 R4 A still old at long+1", stat_a, '0);
        edges(1);
        chk("R4 R3 A new at long+2", stat_a, 10'b0000000001);
        chk("R3 B unaffected by upper", stat_b, '0);
    endtask

    task automatic t_short_rise_fall;
        filt_en[1] = 1'b0;
        cmp_lo[1]  = 1'b1;
        edges(FS + 1);
        chk("R2 R5 B still old at short+1", stat_b, '0);
        edges(1);
        chk("R5 R3 B new at short+2", stat_b, 10'b0000000010);
        cmp_lo[1] = 1'b0;
        edges(FS + 1);
        chk("R10 B fall still 1 at short+1", stat_b, 10'b0000000010);
        edges(1);
        chk("R10 B fall done at short+2", stat_b, '0);
    endtask

    task automatic t_bounce;
        filt_en[2] = 1'b0;
        cmp_up[2]  = 1'b1;
        edges(FS - 1);
        cmp_up[2] = 1'b0;
        edges(FS + 40);
        chk("R6 short run rejected", stat_a, 10'b0000000001);
        cmp_up[2] = 1'b1;
        edges(FS);
        cmp_up[2] = 1'b0;
        edges(1);
        chk("R6 exact run not yet", stat_a, 10'b0000000001);
        edges(1);
        chk("R6 exact run accepted", stat_a, 10'b0000000101);
        edges(FS + 4);
        chk("R6 settles back", stat_a, 10'b0000000001);
    endtask

    task automatic t_window;
        filt_en[3] = 1'b0;
        win_en[3]  = 1'b1;
        edges(4);
        cmp_lo[3] = 1'b1;
        edges(FS + 2);
        chk("R7 in window A", stat_a, 10'b0000001001);
        chk("R8 window B", stat_b, 10'b0000001000);
        cmp_up[3] = 1'b1;
        edges(FS + 1);
        chk("R7 over limit A still 1", stat_a, 10'b0000001001);
        edges(1);
        chk("R7 over limit A clears", stat_a, 10'b0000000001);
        chk("R8 B holds lower", stat_b, 10'b0000001000);
    endtask

    task automatic t_indep;
        filt_en[4] = 1'b1;
        filt_en[5] = 1'b0;
        cmp_up[4]  = 1'b1;
        cmp_up[5]  = 1'b1;
        edges(FS + 2);
        chk("R9 short channel only", stat_a, 10'b0000100001);
        edges(FL - FS - 1);
        chk("R9 long channel not yet", stat_a, 10'b0000100001);
        edges(1);
        chk("R9 long channel done", stat_a, 10'b0000110001);
        chk("R9 B column untouched", stat_b, 10'b0000001000);
    endtask

    initial begin
        t_reset();
        t_filtered_rise();
        t_short_rise_fall();
        t_bounce();
        t_window();
        t_indep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 150000; k++) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule